// File: doc/BRIEF.md
# Video Sync Validation Filter

This block sits between the raw horizontal sync, vertical sync and field-identifier pins of a video input and the line and field logic that follows. All three pins run on the pixel clock. Each pin passes through its own polarity inverter, a two-flop synchronizer and a rising-edge detector, so software can pick which physical edge starts a line or a field.

Syncs that arrive too soon after the last accepted one are discarded. For lines, the limit is a minimum number of clocks. For fields, the limit is a minimum number of accepted lines. A field whose parity repeats the last accepted field's parity is dropped as well. The cleaned result is a one-cycle line-start strobe, a one-cycle field-start strobe, and a held field parity flag.

A mode input selects whether the sync pins are used at all. When syncs travel embedded in the data stream, the pins are ignored. All programmable values arrive on plain input ports. The minimum line length is normally 1706 clocks and the minimum field length is normally 300 lines.

Top module: `sync_gate`

## Requirements
- R1: An accepted selected edge on `hs_in` produces `line_start` high for exactly one cycle, three clock edges after the input edge is set up. An accepted selected edge on `vs_in` likewise produces a single-cycle `field_start`, three clock edges after the input edge is set up.
- R2: With `hs_pol`/`vs_pol` at 0, the rising edge of the pin is the selected edge. With the control at 1, the falling edge is selected. The opposite edge never produces a strobe.
- R3: After the first accepted line, a selected horizontal edge is accepted only if at least `h_min` clocks have passed since the previous accepted horizontal edge. A rejected edge does not restart this interval.
- R4: The first selected horizontal edge after reset is accepted with no interval check.
- R5: After the first accepted field, a selected vertical edge is accepted only if at least `v_min` lines have been accepted since the previous accepted field. A dropped field does not reset this line count.
- R6: A vertical edge whose sampled parity equals the parity of the last accepted field is dropped. A dropped edge leaves `field_odd` and the line count untouched.
- R7: `field_odd` takes the value (`fid_in` XOR `fid_pol`), sampled through the same synchronizer depth as `vs_in`. It is updated in the cycle in which `field_start` is high and holds its value in every other cycle.
- R8: The first selected vertical edge after reset is accepted regardless of line count and parity.
- R9: While `ext_mode` is 0, the sync pins produce no strobes and add nothing to the field line count.
- R10: During and right after reset, `line_start`, `field_start` and `field_odd` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | 1: use the sync pins; 0: syncs are embedded, pins ignored |
| hs_pol | input | 1 | Horizontal edge select (0 rising, 1 falling) |
| vs_pol | input | 1 | Vertical edge select (0 rising, 1 falling) |
| fid_pol | input | 1 | Inverts the field-identifier level |
| h_min | input | HW | Minimum clocks between accepted lines |
| v_min | input | VW | Minimum accepted lines between accepted fields |
| hs_in | input | 1 | Raw horizontal sync pin |
| vs_in | input | 1 | Raw vertical sync pin |
| fid_in | input | 1 | Raw field-identifier pin |
| line_start | output | 1 | One-cycle accepted line strobe |
| field_start | output | 1 | One-cycle accepted field strobe |
| field_odd | output | 1 | Parity of the last accepted field |

## Verification
The bench sweeps the spacing between horizontal edges across the `h_min` boundary, from a few clocks short to a few clocks long. An off-by-one compare shows up as a wrong strobe at exactly one spacing. It also places a rejected edge between two legal ones; a design that restarted its interval on rejection would then lose the legal edge. Field tests sweep the line count across `v_min`, repeat a parity, and follow a dropped field with a legal one, which exposes any design that clears its line count or parity on a drop. Polarity and mode tests drive the non-selected edge and pin activity in embedded mode, where a design that ignored these controls would emit strobes or count lines it should not.

// File: rtl/sync_gate.sv
module sync_gate #(
  parameter int HW = 11,
  parameter int VW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_mode,
  input  logic          hs_pol,
  input  logic          vs_pol,
  input  logic          fid_pol,
  input  logic [HW-1:0] h_min,
  input  logic [VW-1:0] v_min,
  input  logic          hs_in,
  input  logic          vs_in,
  input  logic          fid_in,
  output logic          line_start,
  output logic          field_start,
  output logic          field_odd
);

  logic [2:0]    hs_p, vs_p;
  logic [1:0]    fid_p;
  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic          h_seen, v_seen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hs_p  <= '0;
      vs_p  <= '0;
      fid_p <= '0;
    end else begin
      hs_p  <= {hs_p[1:0], hs_in ^ hs_pol};
      vs_p  <= {vs_p[1:0], vs_in ^ vs_pol};
      fid_p <= {fid_p[0], fid_in ^ fid_pol};
    end

  wire h_edge = hs_p[1] & ~hs_p[2];
  wire v_edge = vs_p[1] & ~vs_p[2];
  wire fid_now = fid_p[1];

  wire h_ok  = !h_seen || (h_cnt >= h_min);
  wire h_acc = ext_mode && h_edge && h_ok;
  wire v_ok  = !v_seen || ((v_cnt >= v_min) && (fid_now != field_odd));
  wire v_acc = ext_mode && v_edge && v_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      h_cnt  <= '0;
      h_seen <= 1'b0;
    end else if (h_acc) begin
      h_cnt  <= HW'(1);
      h_seen <= 1'b1;
    end else if (h_cnt != '1) begin
      h_cnt  <= h_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v_cnt     <= '0;
      v_seen    <= 1'b0;
      field_odd <= 1'b0;
    end else if (v_acc) begin
      v_cnt     <= h_acc ? VW'(1) : '0;
      v_seen    <= 1'b1;
      field_odd <= fid_now;
    end else if (h_acc && v_cnt != '1) begin
      v_cnt     <= v_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      line_start  <= 1'b0;
      field_start <= 1'b0;
    end else begin
      line_start  <= h_acc;
      field_start <= v_acc;
    end

  logic [HW-1:0] a_hgap;
  logic          a_hseen, a_fseen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_hgap  <= '0;
      a_hseen <= 1'b0;
      a_fseen <= 1'b0;
    end else begin
      if (line_start) begin
        a_hgap  <= HW'(1);
        a_hseen <= 1'b1;
      end else if (a_hgap != '1) begin
        a_hgap  <= a_hgap + 1'b1;
      end
      if (field_start) a_fseen <= 1'b1;
    end

  p_line_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !line_start);

  p_field_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> !field_start);

  p_line_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> (!a_hseen || a_hgap >= h_min));

  p_parity_alt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start && a_fseen) |-> (field_odd != $past(field_odd)));

  p_odd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start |-> $stable(field_odd));

  p_pins_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ext_mode) |-> (!line_start && !field_start));

endmodule

// File: tb/sync_gate_tb.sv
`timescale 1ns/1ps
module sync_gate_tb;
  localparam int HW = 11;
  localparam int VW = 9;
  localparam int HMIN = 20;
  localparam int VMIN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_mode = 1'b1;
  logic hs_pol = 1'b0, vs_pol = 1'b0, fid_pol = 1'b0;
  logic hs_act = 1'b0, vs_act = 1'b0, fid_act = 1'b0;
  logic line_start, field_start, field_odd;
  int checks = 0, fails = 0;
  logic par;

  always #4 clk = ~clk;

  sync_gate #(.HW(HW), .VW(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode),
    .hs_pol(hs_pol), .vs_pol(vs_pol), .fid_pol(fid_pol),
    .h_min(HW'(HMIN)), .v_min(VW'(VMIN)),
    .hs_in(hs_act ^ hs_pol), .vs_in(vs_act ^ vs_pol), .fid_in(fid_act ^ fid_pol),
    .line_start(line_start), .field_start(field_start), .field_odd(field_odd));

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    hs_act = 0; vs_act = 0; fid_act = 0;
    wait_n(3);
    chk(line_start, 1'b0, "R10");
    chk(field_start, 1'b0, "R10");
    chk(field_odd, 1'b0, "R10");
    rst_n = 1'b1;
    wait_n(4);
    chk(line_start | field_start | field_odd, 1'b0, "R10");
  endtask

  task automatic h_edge(input logic exp, input string req);
    hs_act = 1'b1;
    wait_n(3);
    chk(line_start, exp, req);
    hs_act = 1'b0;
    wait_n(1);
    chk(line_start, 1'b0, "R1");
    wait_n(2);
    chk(line_start, 1'b0, "R2");
  endtask

  task automatic v_edge(input logic exp, input logic fid, input logic exp_odd, input string req);
    fid_act = fid;
    vs_act = 1'b1;
    wait_n(3);
    chk(field_start, exp, req);
    chk(field_odd, exp_odd, "R7");
    vs_act = 1'b0;
    wait_n(1);
    chk(field_start, 1'b0, "R1");
    wait_n(2);
    chk(field_start, 1'b0, "R2");
    chk(field_odd, exp_odd, "R7");
  endtask

  task automatic lines(input int n);
    for (int i = 0; i < n; i++) begin
      wait_n(HMIN);
      h_edge(1'b1, "R3");
    end
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    h_edge(1'b1, "R4");
    h_edge(1'b0, "R3");
    for (int d = HMIN - 3; d <= HMIN + 3; d++) begin
      wait_n(30);
      h_edge(1'b1, "R3");
      wait_n(d - 6);
      h_edge(d >= HMIN, "R3");
    end
    wait_n(30);
    h_edge(1'b1, "R3");
    wait_n(8);
    h_edge(1'b0, "R3");
    h_edge(1'b1, "R3");
    hs_pol = 1'b1;
    wait_n(30);
    h_edge(1'b1, "R2");
    wait_n(20);
    h_edge(1'b1, "R2");
    hs_pol = 1'b0;
    wait_n(30);

    do_reset();
    v_edge(1'b1, 1'b1, 1'b1, "R8");
    lines(3);
    v_edge(1'b0, 1'b1, 1'b1, "R6");
    v_edge(1'b1, 1'b0, 1'b0, "R6");
    lines(2);
    v_edge(1'b0, 1'b1, 1'b0, "R5");
    lines(1);
    v_edge(1'b1, 1'b1, 1'b1, "R5");
    par = 1'b1;
    for (int k = 0; k <= 5; k++) begin
      lines(k);
      if (k >= VMIN) begin
        v_edge(1'b1, ~par, ~par, "R5");
        par = ~par;
      end else begin
        v_edge(1'b0, ~par, par, "R5");
        lines(VMIN);
        v_edge(1'b1, ~par, ~par, "R5");
        par = ~par;
      end
    end
    fid_act = ~par;
    wait_n(6);
    chk(field_odd, par, "R7");
    vs_pol = 1'b1;
    lines(3);
    v_edge(1'b1, ~par, ~par, "R2");
    par = ~par;
    vs_pol = 1'b0;
    fid_pol = 1'b1;
    lines(3);
    v_edge(1'b1, ~par, ~par, "R7");
    par = ~par;
    fid_pol = 1'b0;

    wait_n(4);
    ext_mode = 1'b0;
    wait_n(30);
    h_edge(1'b0, "R9");
    v_edge(1'b0, ~par, par, "R9");
    for (int i = 0; i < 3; i++) begin
      wait_n(HMIN);
      h_edge(1'b0, "R9");
    end
    ext_mode = 1'b1;
    wait_n(4);
    v_edge(1'b0, ~par, par, "R9");
    wait_n(30);
    h_edge(1'b1, "R9");
    lines(2);
    v_edge(1'b1, ~par, ~par, "R5");

    wait_n(5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule